// File: doc/BRIEF.md
# Bi-phase-mark Timing Data Link Receiver

This block recovers frames from a serial timing link whose bits are bi-phase-mark coded. The line always toggles at every bit-cell boundary, and a one also toggles in the middle of its cell. The receiver samples the line with a local clock that runs `OVS` times faster than the bit rate, so a 10 MHz link with the default `OVS = 8` needs an 80 MHz sampling clock. It measures the time between line transitions and sorts each gap into a half cell, a full cell or an illegal length. Half cells come in pairs and decode to a one, and a full cell decodes to a zero.

The link is idle, sending zeros, until the flag byte 0x7E arrives. The next 40 bits form one frame: an 8-bit frame number, 24 data bits and an 8-bit CRC, each sent most significant bit first. At the end of a frame the receiver raises a strobe and presents the frame number and the data word, together with two error flags that act as beam-abort conditions: one for a CRC mismatch and one for a coding fault. A separate fault flag reports when the carrier timing drifts out of tolerance or the carrier stops.

Frame number 5 carries the machine mode, coded three times over. The receiver checks this coding and keeps the last mode that was accepted in a register of its own.

Top module: `rtdl_rx`

## Requirements
- R1: A gap of 7 to 9 sample clocks between transitions decodes to a 0. Two gaps of 3 to 5 clocks in a row decode to a 1. `data_clk_o` pulses for exactly one clock for each decoded bit, so a run of K closed bit cells that follows an idle line gives K pulses.
- R2: After the receiver sees the decoded byte 0x7E, it collects 40 bits in this order: frame number in bits 39..32, data in bits 31..8 and CRC in bits 7..0, all sent most significant bit first. It then pulses `valid_o` once and presents `frame_o` and `data_o`. The receiver then looks for a new flag.
- R3: The CRC uses the polynomial x^8+x^2+x+1 (0x07), starts from zero and covers the frame number and the data. When the received CRC does not match, `crc_err_o` is 1 for that frame. Otherwise it is 0.
- R4: `code_err_o` is 1 for a frame in which the receiver sees any of these: a gap that falls outside both windows, a half cell with no partner, or a cell boundary with no transition. If the line is silent for 2*OVS clocks, the frame ends at once with `valid_o`, `code_err_o`=1 and `crc_err_o`=0.
- R5: `freq_fault_o` is 1 out of reset. It is set again by any gap that falls outside both windows, and by 2*OVS clocks with no transition. It clears only after GOOD_RUN gaps in a row that fall inside a window.
- R6: A frame number 5 that arrives with no error and with data bytes hi, mid and lo is accepted when hi == lo and mid == (hi*hi+1) mod 256. On acceptance `mode_o` becomes hi and `mode_err_o` becomes 0.
- R7: A frame number 5 that arrives with no error but fails the R6 coding check sets `mode_err_o` to 1 and leaves `mode_o` unchanged.
- R8: A frame with any other number, and any frame with a CRC or coding error, leaves `mode_o` and `mode_err_o` unchanged.
- R9: After reset, `valid_o`, `crc_err_o`, `code_err_o`, `mode_o` and `mode_err_o` are 0.
- R10: `valid_o` is high for a single clock. `frame_o`, `data_o`, `crc_err_o` and `code_err_o` change only in a cycle where `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, OVS times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Bi-phase-mark coded link input |
| valid_o | output | 1 | One-clock strobe at the end of each frame |
| frame_o | output | 8 | Number of the last frame |
| data_o | output | 24 | Data word of the last frame |
| crc_err_o | output | 1 | CRC mismatch in the last frame (abort) |
| code_err_o | output | 1 | Coding fault in the last frame (abort) |
| data_clk_o | output | 1 | One-clock pulse for each recovered bit |
| freq_fault_o | output | 1 | Carrier timing out of tolerance, or carrier lost |
| mode_o | output | 8 | Last accepted machine mode |
| mode_err_o | output | 1 | Last mode frame failed its coding check |

## Verification
The assertions check on every cycle that the frame strobe lasts one clock, that the frame outputs hold their values between strobes, that the mode register changes only on an error-free mode frame whose three bytes agree, and that recovered bit pulses never touch each other. Only the bench scenarios can show that the decoded bits and the CRC verdict are right, and that the mode arithmetic wraps around modulo 256. The same holds for a frame cut short when a cell boundary loses its transition, and for the fault flag setting and then clearing over a run of good gaps.

// File: rtl/rtdl_rx_pkg.sv
package rtdl_rx_pkg;

    // Widths of the frame body fields, fixed by the link protocol
    localparam int FNUM_W = 8;
    localparam int DATA_W = 24;
    localparam int CRC_W  = 8;
    localparam int BODY_W = FNUM_W + DATA_W + CRC_W;
    localparam int BCNT_W = $clog2(BODY_W + 1);

    localparam logic [7:0] SYNC_FLAG = 8'h7E;
    localparam logic [7:0] CRC_POLY  = 8'h07;

    typedef enum logic [1:0] {
        IVL_SHORT = 2'd0,
        IVL_LONG  = 2'd1,
        IVL_BAD   = 2'd2
    } ivl_kind_e;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_RECV = 1'b1
    } asm_state_e;

    // One step of the serial CRC, processing one bit MSB first
    function automatic logic [7:0] crc8_next(input logic [7:0] c, input logic b);
        crc8_next = {c[6:0], 1'b0} ^ ((c[7] ^ b) ? CRC_POLY : 8'h00);
    endfunction

endpackage

// File: rtl/rtdl_edge_timer.sv
module rtdl_edge_timer
    import rtdl_rx_pkg::*;
#(
    parameter int OVS      = 8,
    parameter int GOOD_RUN = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      line_i,
    output logic      evt_o,
    output ivl_kind_e kind_o,
    output logic      tmo_o,
    output logic      fault_o
);
    localparam int HALF = OVS / 2;
    localparam int TMO  = 2 * OVS;
    localparam int CW   = $clog2(TMO + 1);
    localparam int RW   = $clog2(GOOD_RUN + 1);

    localparam logic [CW-1:0] S_MIN_C  = CW'(HALF - 1);
    localparam logic [CW-1:0] S_MAX_C  = CW'(HALF + 1);
    localparam logic [CW-1:0] L_MIN_C  = CW'(OVS - 1);
    localparam logic [CW-1:0] L_MAX_C  = CW'(OVS + 1);
    localparam logic [CW-1:0] TMO_C    = CW'(TMO);
    localparam logic [CW-1:0] TMO_M1_C = CW'(TMO - 1);
    localparam logic [CW-1:0] ONE_C    = CW'(1);
    localparam logic [RW-1:0] RUN_MAX  = RW'(GOOD_RUN);
    localparam logic [RW-1:0] RUN_LAST = RW'(GOOD_RUN - 1);
    localparam logic [RW-1:0] RUN_ONE  = RW'(1);

    typedef struct packed {
        logic [2:0]    sync;
        logic [CW-1:0] cnt;
        logic [RW-1:0] run;
        logic          fault;
        logic          evt;
        logic          tmo;
        ivl_kind_e     kind;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic seen_d;

    always_comb begin
        tmr_d      = tmr_q;
        seen_d     = tmr_q.sync[2] ^ tmr_q.sync[1];
        tmr_d.sync = {tmr_q.sync[1:0], line_i};
        tmr_d.evt  = seen_d;
        tmr_d.tmo  = 1'b0;
        tmr_d.kind = IVL_BAD;
        if (seen_d) begin
            tmr_d.cnt = ONE_C;
            if (tmr_q.cnt >= S_MIN_C && tmr_q.cnt <= S_MAX_C)
                tmr_d.kind = IVL_SHORT;
            else if (tmr_q.cnt >= L_MIN_C && tmr_q.cnt <= L_MAX_C)
                tmr_d.kind = IVL_LONG;
            if (tmr_d.kind == IVL_BAD) begin
                tmr_d.fault = 1'b1;
                tmr_d.run   = '0;
            end else begin
                if (tmr_q.run != RUN_MAX) tmr_d.run = tmr_q.run + RUN_ONE;
                if (tmr_q.run >= RUN_LAST) tmr_d.fault = 1'b0;
            end
        end else if (tmr_q.cnt != TMO_C) begin
            tmr_d.cnt = tmr_q.cnt + ONE_C;
            if (tmr_q.cnt == TMO_M1_C) begin
                tmr_d.tmo   = 1'b1;
                tmr_d.fault = 1'b1;
                tmr_d.run   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q.sync  <= '0;
            tmr_q.cnt   <= TMO_C;
            tmr_q.run   <= '0;
            tmr_q.fault <= 1'b1;
            tmr_q.evt   <= 1'b0;
            tmr_q.tmo   <= 1'b0;
            tmr_q.kind  <= IVL_BAD;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign evt_o   = tmr_q.evt;
    assign kind_o  = tmr_q.kind;
    assign tmo_o   = tmr_q.tmo;
    assign fault_o = tmr_q.fault;

endmodule

// File: rtl/rtdl_bit_decoder.sv
module rtdl_bit_decoder
    import rtdl_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      evt_i,
    input  ivl_kind_e kind_i,
    input  logic      tmo_i,
    output logic      bit_stb_o,
    output logic      bit_o,
    output logic      viol_o
);
    typedef struct packed {
        logic half;
        logic stb;
        logic bitv;
        logic viol;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d      = dec_q;
        dec_d.stb  = 1'b0;
        dec_d.viol = 1'b0;
        if (tmo_i) begin
            dec_d.half = 1'b0;
            dec_d.viol = 1'b1;
        end else if (evt_i) begin
            case (kind_i)
                IVL_SHORT: begin
                    if (dec_q.half) begin
                        dec_d.stb  = 1'b1;
                        dec_d.bitv = 1'b1;
                        dec_d.half = 1'b0;
                    end else begin
                        dec_d.half = 1'b1;
                    end
                end
                IVL_LONG: begin
                    if (dec_q.half) begin
                        dec_d.viol = 1'b1;
                        dec_d.half = 1'b0;
                    end else begin
                        dec_d.stb  = 1'b1;
                        dec_d.bitv = 1'b0;
                    end
                end
                default: begin
                    dec_d.viol = 1'b1;
                    dec_d.half = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign bit_stb_o = dec_q.stb;
    assign bit_o     = dec_q.bitv;
    assign viol_o    = dec_q.viol;

endmodule

// File: rtl/rtdl_frame_asm.sv
module rtdl_frame_asm
    import rtdl_rx_pkg::*;
#(
    parameter logic [7:0] MODE_FRAME = 8'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb_i,
    input  logic              bit_i,
    input  logic              viol_i,
    input  logic              tmo_i,
    output logic              valid_o,
    output logic [FNUM_W-1:0] frame_o,
    output logic [DATA_W-1:0] data_o,
    output logic              crc_err_o,
    output logic              code_err_o,
    output logic [7:0]        mode_o,
    output logic              mode_err_o
);
    localparam logic [BCNT_W-1:0] LAST_C = BCNT_W'(BODY_W - 1);
    localparam logic [BCNT_W-1:0] BC_ONE = BCNT_W'(1);

    typedef struct packed {
        asm_state_e        state;
        logic [7:0]        hunt;
        logic [BODY_W-1:0] body;
        logic [BCNT_W-1:0] bcnt;
        logic [CRC_W-1:0]  crc;
        logic              cflag;
        logic              valid;
        logic [FNUM_W-1:0] frame;
        logic [DATA_W-1:0] data;
        logic              crc_err;
        logic              code_err;
        logic [7:0]        mode;
        logic              merr;
    } asm_t;

    asm_t asm_d, asm_q;
    logic       fin, fin_crc, fin_code;
    logic [7:0] shifted, crc_nx, enc_hi, enc_mid, enc_lo, mid_exp;
    logic       enc_ok;

    always_comb begin
        asm_d       = asm_q;
        asm_d.valid = 1'b0;
        fin         = 1'b0;
        fin_crc     = 1'b0;
        fin_code    = 1'b0;
        shifted     = {asm_q.hunt[6:0], bit_i};
        crc_nx      = crc8_next(asm_q.crc, bit_i);
        case (asm_q.state)
            ST_HUNT: begin
                if (bit_stb_i) begin
                    asm_d.hunt = shifted;
                    if (shifted == SYNC_FLAG) begin
                        asm_d.state = ST_RECV;
                        asm_d.hunt  = '0;
                        asm_d.bcnt  = '0;
                        asm_d.crc   = '0;
                        asm_d.cflag = 1'b0;
                    end
                end
            end
            default: begin
                if (tmo_i) begin
                    fin      = 1'b1;
                    fin_code = 1'b1;
                end else begin
                    if (viol_i) asm_d.cflag = 1'b1;
                    if (bit_stb_i) begin
                        asm_d.body = {asm_q.body[BODY_W-2:0], bit_i};
                        asm_d.crc  = crc_nx;
                        asm_d.bcnt = asm_q.bcnt + BC_ONE;
                        if (asm_q.bcnt == LAST_C) begin
                            fin      = 1'b1;
                            fin_crc  = (crc_nx != '0);
                            fin_code = asm_q.cflag;
                        end
                    end
                end
            end
        endcase

        // Triple-coded mode check on the assembled body
        enc_hi  = asm_d.body[CRC_W+16 +: 8];
        enc_mid = asm_d.body[CRC_W+8 +: 8];
        enc_lo  = asm_d.body[CRC_W +: 8];
        mid_exp = enc_hi * enc_hi + 8'd1;
        enc_ok  = (enc_hi == enc_lo) && (enc_mid == mid_exp);

        if (fin) begin
            asm_d.state    = ST_HUNT;
            asm_d.hunt     = '0;
            asm_d.valid    = 1'b1;
            asm_d.frame    = asm_d.body[BODY_W-1 -: FNUM_W];
            asm_d.data     = asm_d.body[CRC_W +: DATA_W];
            asm_d.crc_err  = fin_crc;
            asm_d.code_err = fin_code;
            if (asm_d.frame == MODE_FRAME && !fin_crc && !fin_code) begin
                if (enc_ok) begin
                    asm_d.mode = enc_hi;
                    asm_d.merr = 1'b0;
                end else begin
                    asm_d.merr = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asm_q       <= '0;
            asm_q.state <= ST_HUNT;
        end else begin
            asm_q <= asm_d;
        end
    end

    assign valid_o    = asm_q.valid;
    assign frame_o    = asm_q.frame;
    assign data_o     = asm_q.data;
    assign crc_err_o  = asm_q.crc_err;
    assign code_err_o = asm_q.code_err;
    assign mode_o     = asm_q.mode;
    assign mode_err_o = asm_q.merr;

endmodule

// File: rtl/rtdl_rx.sv
module rtdl_rx
    import rtdl_rx_pkg::*;
#(
    parameter int         OVS        = 8,
    parameter int         GOOD_RUN   = 16,
    parameter logic [7:0] MODE_FRAME = 8'd5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_i,
    output logic        valid_o,
    output logic [7:0]  frame_o,
    output logic [23:0] data_o,
    output logic        crc_err_o,
    output logic        code_err_o,
    output logic        data_clk_o,
    output logic        freq_fault_o,
    output logic [7:0]  mode_o,
    output logic        mode_err_o
);
    logic      evt, tmo, bit_stb, bit_val, viol;
    ivl_kind_e kind;

    rtdl_edge_timer #(.OVS(OVS), .GOOD_RUN(GOOD_RUN)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (line_i),
        .evt_o   (evt),
        .kind_o  (kind),
        .tmo_o   (tmo),
        .fault_o (freq_fault_o)
    );

    rtdl_bit_decoder u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .kind_i    (kind),
        .tmo_i     (tmo),
        .bit_stb_o (bit_stb),
        .bit_o     (bit_val),
        .viol_o    (viol)
    );

    rtdl_frame_asm #(.MODE_FRAME(MODE_FRAME)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb_i  (bit_stb),
        .bit_i      (bit_val),
        .viol_i     (viol),
        .tmo_i      (tmo),
        .valid_o    (valid_o),
        .frame_o    (frame_o),
        .data_o     (data_o),
        .crc_err_o  (crc_err_o),
        .code_err_o (code_err_o),
        .mode_o     (mode_o),
        .mode_err_o (mode_err_o)
    );

    assign data_clk_o = bit_stb;

endmodule

// File: rtl/rtdl_rx_chk.sv
module rtdl_rx_chk #(
    parameter logic [7:0] MODE_FRAME = 8'd5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_o,
    input logic [7:0]  frame_o,
    input logic [23:0] data_o,
    input logic        crc_err_o,
    input logic        code_err_o,
    input logic        data_clk_o,
    input logic [7:0]  mode_o,
    input logic        mode_err_o
);
    logic [7:0] sq_plus1;
    assign sq_plus1 = data_o[23:16] * data_o[23:16] + 8'd1;

    logic clean_mode;
    assign clean_mode = valid_o && (frame_o == MODE_FRAME) && !crc_err_o && !code_err_o;

    a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(frame_o) && $stable(data_o) && $stable(crc_err_o) && $stable(code_err_o)));

    a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clean_mode |-> ($stable(mode_o) && $stable(mode_err_o)));

    a_r6_mode_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_mode && !mode_err_o) |->
            (mode_o == data_o[23:16] && data_o[7:0] == data_o[23:16] && data_o[15:8] == sq_plus1));

    a_r7_mode_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_mode && mode_err_o) |-> $stable(mode_o));

    a_r1_bit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        data_clk_o |=> !data_clk_o);

endmodule

bind rtdl_rx rtdl_rx_chk #(.MODE_FRAME(MODE_FRAME)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_o    (valid_o),
    .frame_o    (frame_o),
    .data_o     (data_o),
    .crc_err_o  (crc_err_o),
    .code_err_o (code_err_o),
    .data_clk_o (data_clk_o),
    .mode_o     (mode_o),
    .mode_err_o (mode_err_o)
);

// File: tb/sim_rtdl_rx.sv
module sim_rtdl_rx;
    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 8;
    localparam int GOOD_RUN   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line = 1'b0;
    logic        valid_o, crc_err_o, code_err_o, data_clk_o, freq_fault_o, mode_err_o;
    logic [7:0]  frame_o, mode_o;
    logic [23:0] data_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rtdl_rx #(.OVS(OVS), .GOOD_RUN(GOOD_RUN), .MODE_FRAME(8'd5)) u0 (
        .clk(clk), .rst_n(rst_n), .line_i(line),
        .valid_o(valid_o), .frame_o(frame_o), .data_o(data_o),
        .crc_err_o(crc_err_o), .code_err_o(code_err_o), .data_clk_o(data_clk_o),
        .freq_fault_o(freq_fault_o), .mode_o(mode_o), .mode_err_o(mode_err_o)
    );

    typedef struct {
        logic [7:0]  fn;
        logic [23:0] data;
        logic        crc_err;
        logic        code_err;
        logic        chk_body;
        logic [7:0]  mode;
        logic        merr;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         errors = 0;
    int         dclk_cnt = 0;
    bit         done = 1'b0;
    logic [7:0] m_mode = 8'd0;
    logic       m_merr = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [31:0] msg);
        logic [7:0] c = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            logic fb = c[7] ^ msg[i];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tx_bit(input logic b, input int len);
        line = ~line;
        if (b) begin
            wclk(len / 2);
            line = ~line;
            wclk(len - len / 2);
        end else begin
            wclk(len);
        end
    endtask

    task automatic tx_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) tx_bit(v[i], OVS);
    endtask

    task automatic tx_idle(input int n);
        for (int i = 0; i < n; i++) tx_bit(1'b0, OVS);
    endtask

    // Sends flag and body; glitch >= 0 shortens that body bit (must be a 0) to 6 clocks
    task automatic send_frame(input logic [7:0] fn, input logic [23:0] data,
                              input logic flip, input int glitch);
        exp_t        e;
        logic [39:0] body;
        logic [7:0]  c;
        logic [7:0]  hi, mid, lo, m2;
        c    = ref_crc({fn, data}) ^ (flip ? 8'h01 : 8'h00);
        body = {fn, data, c};
        hi = data[23:16]; mid = data[15:8]; lo = data[7:0];
        m2 = hi * hi + 8'd1;
        if (fn == 8'd5 && !flip && glitch < 0) begin
            if (hi == lo && mid == m2) begin m_mode = hi; m_merr = 1'b0; end
            else m_merr = 1'b1;
        end
        e.fn = fn; e.data = data; e.crc_err = flip; e.code_err = (glitch >= 0);
        e.chk_body = (glitch < 0); e.mode = m_mode; e.merr = m_merr;
        sb.push_back(e);
        tx_byte(8'h7E);
        for (int i = 0; i < 40; i++) begin
            if (i == glitch) tx_bit(1'b0, 6);
            else             tx_bit(body[39-i], OVS);
            if (glitch >= 0 && i == glitch + 1)
                check("R5 out-of-window gap sets freq_fault", freq_fault_o, 1);
        end
        tx_idle(3);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (sb.size() == 0) begin
                check("R2 unexpected frame strobe", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.chk_body) begin
                    check("R2 frame number", frame_o, e.fn);
                    check("R2 data word", data_o, e.data);
                    check("R3 crc_err", crc_err_o, e.crc_err);
                end
                check("R4 code_err", code_err_o, e.code_err);
                check("R6/R7/R8 mode_o", mode_o, e.mode);
                check("R6/R7/R8 mode_err_o", mode_err_o, e.merr);
            end
        end
    end

    always @(negedge clk) if (data_clk_o) dclk_cnt++;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t e;
        wclk(3);
        rst_n = 1'b1;
        wclk(2);
        check("R9 valid after reset", valid_o, 0);
        check("R9 crc_err after reset", crc_err_o, 0);
        check("R9 code_err after reset", code_err_o, 0);
        check("R9 mode after reset", mode_o, 0);
        check("R9 mode_err after reset", mode_err_o, 0);
        check("R5 freq_fault after reset", freq_fault_o, 1);

        tx_idle(24);
        check("R5 freq_fault clears after good run", freq_fault_o, 0);

        send_frame(8'h01, 24'h123456, 1'b0, -1);
        send_frame(8'h09, 24'hFFFFFF, 1'b0, -1);              // R1 long runs of ones
        send_frame(8'h05, {8'd3, 8'd10, 8'd3}, 1'b0, -1);    // R6
        send_frame(8'h05, {8'd7, 8'd50, 8'd7}, 1'b0, -1);    // R6
        send_frame(8'h05, {8'd16, 8'd1, 8'd16}, 1'b0, -1);   // R6 wrap modulo 256
        send_frame(8'h05, {8'd4, 8'd17, 8'd5}, 1'b0, -1);    // R7 hi != lo
        send_frame(8'h06, {8'd8, 8'd65, 8'd8}, 1'b0, -1);    // R8 other frame
        send_frame(8'h05, {8'd9, 8'd82, 8'd9}, 1'b1, -1);    // R3 R8 bad CRC
        send_frame(8'h05, {8'd2, 8'd5, 8'd2}, 1'b0, -1);     // R6
        send_frame(8'h05, {8'd4, 8'd18, 8'd4}, 1'b0, -1);    // R7 mid wrong
        send_frame(8'h03, 24'h00A5F0, 1'b0, 0);              // R4 out-of-window gap
        tx_idle(20);
        check("R5 freq_fault clears again", freq_fault_o, 0);

        // R4: cell boundary without transition ends the frame early
        e.fn = 8'h02; e.data = '0; e.crc_err = 1'b0; e.code_err = 1'b1;
        e.chk_body = 1'b0; e.mode = m_mode; e.merr = m_merr;
        sb.push_back(e);
        tx_byte(8'h7E);
        tx_byte(8'h02);
        for (int i = 0; i < 4; i++) tx_bit(1'b0, OVS);
        wclk(OVS);
        tx_bit(1'b0, OVS);
        check("R5 missing transition sets freq_fault", freq_fault_o, 1);
        tx_idle(24);
        check("R5 freq_fault clears after recovery", freq_fault_o, 0);

        send_frame(8'h05, {8'd1, 8'd2, 8'd1}, 1'b0, -1);     // R6 after recovery

        wclk(40);
        check("R5 carrier stop sets freq_fault", freq_fault_o, 1);
        check("R2 all frames delivered", sb.size(), 0);

        // R1: ten closed bit cells after an idle line give ten pulses
        dclk_cnt = 0;
        tx_bit(1'b1, OVS); tx_bit(1'b0, OVS); tx_bit(1'b1, OVS); tx_bit(1'b1, OVS);
        tx_bit(1'b0, OVS); tx_bit(1'b0, OVS); tx_bit(1'b1, OVS); tx_bit(1'b1, OVS);
        tx_bit(1'b1, OVS); tx_bit(1'b0, OVS);
        line = ~line;
        wclk(30);
        check("R1 data_clk pulse count", dclk_cnt, 10);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule